// File: doc/BRIEF.md
# Temporal Fence Sequencer

This controller carries out a temporal-fence instruction on an in-order core. Once the decode stage presents a matching instruction, the controller records where execution must resume. It then runs one fixed series of steps: it asks the cache engine to write back dirty lines, and it holds off bus traffic until the count of outstanding transactions reaches zero. Next it wipes the selected SRAM arrays one line per cycle, and it drives a clear to every non-architectural flop for a set number of cycles. Finally it redirects fetch to the address it recorded.

The result is a microarchitectural state that does not depend on what ran before. The register files, the CSR file and the controller's own registers are not connected to the clear, so architectural state is left intact. The immediate field of the instruction selects which arrays are wiped. The other steps always run.

Top module: `tfence_seq`

## Requirements
- R1: The sequence starts only when `trig_valid` is high, `trig_insn[6:0]` is 7'b0001011 and `trig_insn[11:7]` is zero, while the controller is idle. In that case `busy` is high in the cycle after the trigger edge. Any other opcode leaves `busy` and every request output low.
- R2: `redirect_pc` equals `trig_pc + 4` of the accepted trigger and stays stable from acceptance until the redirect.
- R3: `wb_req` rises one cycle after acceptance and stays high until `wb_done` is sampled. `drain_hold` is never high together with `wb_req`, and never before the write-back has completed.
- R4: `drain_hold` is high from the end of write-back until the clear ends. The controller leaves the drain step only in a cycle where `pend_cnt` is zero. No line write and no clear happens before that.
- R5: Array i is selected by bit `12+i` of `trig_insn`. Each selected array receives writes to indexes 0 to LINES-1, one per cycle, with `lclr_sel` one-hot. The arrays are visited in ascending order with no gap cycles. Unselected arrays receive no write.
- R6: `clr_out` is high for exactly CLR_CYC consecutive cycles. It begins after the last line write, or directly after the drain when no array is selected.
- R7: `redirect_valid` is high for exactly one cycle, the cycle right after `clr_out` falls. `busy` is low in the following cycle.
- R8: A trigger that arrives while `busy` is high is ignored. The running sequence keeps its address and its selection.
- R9: After reset the controller is idle and all of its outputs are low.
- R10: With no array selected, no line write occurs and the clear follows the drain directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Decode presents an instruction |
| trig_insn | input | 32 | Instruction word |
| trig_pc | input | PCW | Address of the presented instruction |
| wb_req | output | 1 | Request to the cache write-back engine |
| wb_done | input | 1 | Write-back engine finished |
| drain_hold | output | 1 | Block new external requests and responses |
| pend_cnt | input | CNTW | Outstanding bus transactions |
| lclr_we | output | 1 | Line-clear write strobe |
| lclr_sel | output | NARR | One-hot array select for the line write |
| lclr_idx | output | log2(LINES) | Line index being cleared |
| clr_out | output | 1 | Clear to non-architectural flops |
| redirect_valid | output | 1 | One-cycle redirect of fetch |
| redirect_pc | output | PCW | Resume address |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest cases to reach from the ports are the interleavings: a write-back acknowledgement that arrives late while bus transactions are still retiring, and selection masks with gaps between their set bits, so that the walker has to jump across unselected arrays within one cycle. The stimulus draws random masks, write-back delays and initial outstanding counts from a fixed seed. It also fires a second trigger in the middle of every sequence. Directed runs add the empty mask, the full mask, zero delays and an opcode that must not be accepted.

// File: rtl/tfence_pkg.sv
package tfence_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_WB, ST_DRAIN, ST_LCLR, ST_CLR, ST_RESUME
  } tf_state_e;

  localparam logic [6:0] OPC_TFENCE = 7'b0001011;

  // decode match: custom opcode with a zero destination field
  function automatic logic is_tfence(input logic [11:0] low_bits);
    return (low_bits[6:0] == OPC_TFENCE) && (low_bits[11:7] == 5'd0);
  endfunction
endpackage

// File: rtl/tfence_walk.sv
module tfence_walk #(
  parameter int NARR  = 2,
  parameter int LINES = 16,
  localparam int IW = $clog2(LINES),
  localparam int AW = $clog2(NARR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NARR-1:0] sel,
  output logic            we,
  output logic [NARR-1:0] arr_oh,
  output logic [IW-1:0]   idx,
  output logic            finish
);
  // index of the lowest set bit at or above 'from'; NARR when none
  function automatic logic [AW-1:0] seek(input logic [NARR-1:0] s, input logic [AW-1:0] from);
    logic [AW-1:0] r;
    r = AW'(NARR);
    for (int j = NARR - 1; j >= 0; j--)
      if ((j >= int'(from)) && s[j]) r = AW'(j);
    return r;
  endfunction

  logic            act_q;
  logic [AW-1:0]   a_q;
  logic [IW-1:0]   i_q;
  logic [NARR-1:0] sel_q;
  logic            line_last;
  logic [AW-1:0]   a_next;
  logic [AW-1:0]   a_first;

  assign line_last = (i_q == IW'(LINES - 1));
  assign a_next    = seek(sel_q, a_q + AW'(1));
  assign a_first   = seek(sel, AW'(0));
  assign finish    = act_q && line_last && (a_next == AW'(NARR));
  assign we        = act_q;
  assign idx       = i_q;

  for (genvar g = 0; g < NARR; g++) begin : g_dec
    assign arr_oh[g] = act_q && (a_q == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      a_q   <= '0;
      i_q   <= '0;
      sel_q <= '0;
    end else if (start) begin
      sel_q <= sel;
      a_q   <= a_first;
      i_q   <= '0;
      act_q <= (a_first != AW'(NARR));
    end else if (act_q) begin
      if (line_last) begin
        i_q <= '0;
        if (a_next == AW'(NARR)) act_q <= 1'b0;
        else a_q <= a_next;
      end else begin
        i_q <= i_q + IW'(1);
      end
    end
  end

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !line_last && !start) |=> (idx == $past(idx) + IW'(1)));
  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arr_oh) && (we == (arr_oh != '0)));
endmodule

// File: rtl/tfence_pulse.sv
module tfence_pulse #(
  parameter int CYC = 4,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  logic [CW-1:0] cnt_q;

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= CW'(CYC);
    else if (active) cnt_q <= cnt_q - CW'(1);
  end

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);
endmodule

// File: rtl/tfence_seq.sv
module tfence_seq
  import tfence_pkg::*;
#(
  parameter int PCW     = 64,
  parameter int NARR    = 2,
  parameter int LINES   = 16,
  parameter int CNTW    = 4,
  parameter int CLR_CYC = 4,
  localparam int IW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_valid,
  input  logic [31:0]     trig_insn,
  input  logic [PCW-1:0]  trig_pc,
  output logic            wb_req,
  input  logic            wb_done,
  output logic            drain_hold,
  input  logic [CNTW-1:0] pend_cnt,
  output logic            lclr_we,
  output logic [NARR-1:0] lclr_sel,
  output logic [IW-1:0]   lclr_idx,
  output logic            clr_out,
  output logic            redirect_valid,
  output logic [PCW-1:0]  redirect_pc,
  output logic            busy
);
  tf_state_e       st_q, st_d;
  logic [PCW-1:0]  pc_q;
  logic [NARR-1:0] bm_q;
  logic            accept;
  logic            walk_start, walk_fin;
  logic            pulse_start, pulse_last, pulse_act;
  logic            drained;

  assign accept  = (st_q == ST_IDLE) && trig_valid && is_tfence(trig_insn[11:0]);
  assign drained = (pend_cnt == '0);

  always_comb begin
    st_d        = st_q;
    walk_start  = 1'b0;
    pulse_start = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_SAVE;
      ST_SAVE:  st_d = ST_WB;
      ST_WB:    if (wb_done) st_d = ST_DRAIN;
      ST_DRAIN: if (drained) begin
        if (bm_q != '0) begin st_d = ST_LCLR; walk_start = 1'b1; end
        else begin st_d = ST_CLR; pulse_start = 1'b1; end
      end
      ST_LCLR:  if (walk_fin) begin st_d = ST_CLR; pulse_start = 1'b1; end
      ST_CLR:   if (pulse_last) st_d = ST_RESUME;
      ST_RESUME: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pc_q <= '0;
      bm_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        pc_q <= trig_pc + PCW'(4);
        bm_q <= trig_insn[12 +: NARR];
      end
    end
  end

  tfence_walk #(.NARR(NARR), .LINES(LINES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .sel(bm_q),
    .we(lclr_we), .arr_oh(lclr_sel), .idx(lclr_idx), .finish(walk_fin)
  );

  tfence_pulse #(.CYC(CLR_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(pulse_start),
    .active(pulse_act), .last(pulse_last)
  );

  assign wb_req         = (st_q == ST_WB);
  assign drain_hold     = (st_q == ST_DRAIN) || (st_q == ST_LCLR) || (st_q == ST_CLR);
  assign clr_out        = pulse_act;
  assign redirect_valid = (st_q == ST_RESUME);
  assign redirect_pc    = pc_q;
  assign busy           = (st_q != ST_IDLE);

  assert_wb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_done) |=> wb_req);
  assert_wb_vs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_req && drain_hold));
  assert_pc_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(redirect_pc));
  assert_lclr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lclr_we || clr_out) |-> drain_hold);
  assert_clr_then_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_out) |-> redirect_valid);
  assert_redirect_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!redirect_valid && !busy));
endmodule

// File: tb/tfence_seq_tb.sv
module tfence_seq_tb;
  localparam int PCW = 64, NARR = 2, LINES = 16, CNTW = 4, CLR_CYC = 4;
  localparam int IW = $clog2(LINES);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trig_valid = 1'b0;
  logic [31:0]     trig_insn = '0;
  logic [PCW-1:0]  trig_pc = '0;
  logic            wb_req, wb_done = 1'b0, drain_hold;
  logic [CNTW-1:0] pend_cnt = '0;
  logic            lclr_we, clr_out, redirect_valid, busy;
  logic [NARR-1:0] lclr_sel;
  logic [IW-1:0]   lclr_idx;
  logic [PCW-1:0]  redirect_pc;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  tfence_seq #(.PCW(PCW), .NARR(NARR), .LINES(LINES), .CNTW(CNTW), .CLR_CYC(CLR_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_insn(trig_insn),
    .trig_pc(trig_pc), .wb_req(wb_req), .wb_done(wb_done), .drain_hold(drain_hold),
    .pend_cnt(pend_cnt), .lclr_we(lclr_we), .lclr_sel(lclr_sel), .lclr_idx(lclr_idx),
    .clr_out(clr_out), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // next selected array scanning upward; NARR when none remain
  function automatic int upnext(input logic [19:0] bm, input int from);
    for (int k = from; k < NARR; k++) if (bm[k]) return k;
    return NARR;
  endfunction

  function automatic int nsel(input logic [19:0] bm);
    int c = 0;
    for (int k = 0; k < NARR; k++) c += int'(bm[k]);
    return c;
  endfunction

  task automatic run_fence(input logic [19:0] bm, input logic [PCW-1:0] pc, input int wbd, input int pend);
    int ea, ei, writes, clrlen, wbcnt;
    bit wb_ok, done;
    logic [PCW-1:0] exp_pc;
    ea = upnext(bm, 0); ei = 0; writes = 0; clrlen = 0; wbcnt = 0;
    wb_ok = 0; done = 0; exp_pc = pc + 64'd4;
    @(negedge clk);
    trig_valid = 1'b1; trig_insn = {bm, 5'd0, 7'b0001011}; trig_pc = pc;
    pend_cnt = CNTW'(pend);
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      @(negedge clk);
      trig_valid = 1'b0; wb_done = 1'b0;
      if (cyc == 0) check(busy == 1'b1, "R1 accept", busy, 1);
      if (cyc == 2) begin // R8: second trigger while busy
        trig_valid = 1'b1; trig_insn = {20'hFFFFF, 5'd0, 7'b0001011}; trig_pc = pc ^ 64'h100;
      end
      if (wb_req) begin
        check(!drain_hold, "R3 hold during wb", drain_hold, 0);
        wbcnt++;
        if (wbcnt > wbd) begin wb_done = 1'b1; wb_ok = 1; end
      end
      if (drain_hold && !wb_ok) check(0, "R3 hold before wb done", drain_hold, 0);
      if (lclr_we) begin
        check(drain_hold && pend_cnt == 0, "R4 write after drain", pend_cnt, 0);
        check(ea < NARR && lclr_sel == NARR'(1 << ea), "R5 array select", lclr_sel, 1 << ea);
        check(int'(lclr_idx) == ei, "R5 line index", lclr_idx, ei);
        writes++; ei++;
        if (ei == LINES) begin ei = 0; ea = upnext(bm, ea + 1); end
      end else if (lclr_sel != 0) check(0, "R5 select without write", lclr_sel, 0);
      if (clr_out) begin
        check(ea == NARR, "R6 clear after all writes", ea, NARR);
        check(pend_cnt == 0 && drain_hold, "R4 clear after drain", pend_cnt, 0);
        clrlen++;
      end
      if (redirect_valid) begin
        check(clrlen == CLR_CYC, "R6 clear length", clrlen, CLR_CYC);
        check(!clr_out, "R7 redirect after clear", clr_out, 0);
        check(redirect_pc == exp_pc, "R2/R8 resume address", redirect_pc, exp_pc);
        check(writes == nsel(bm) * LINES, nsel(bm) == 0 ? "R10 no writes" : "R5 write count",
              writes, nsel(bm) * LINES);
        done = 1;
      end
      if (pend_cnt > 0 && cyc[0]) pend_cnt = pend_cnt - 1'b1;
    end
    if (!done) check(0, "R7 redirect never seen", 0, 1);
    @(negedge clk);
    trig_valid = 1'b0; wb_done = 1'b0;
    check(!busy && !redirect_valid, "R7 back to idle", {busy, redirect_valid}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check({wb_req, drain_hold, lclr_we, clr_out, redirect_valid, busy} == 0, "R9 in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({wb_req, drain_hold, lclr_we, lclr_sel, clr_out, redirect_valid, busy, redirect_pc} == 0,
          "R9 after reset", busy, 0);

    // R1: wrong opcode, then nonzero destination field
    trig_valid = 1'b1; trig_insn = {20'h3, 5'd0, 7'b0110111}; trig_pc = 64'h1000;
    @(negedge clk); trig_valid = 1'b0;
    check(!busy && !wb_req, "R1 wrong opcode ignored", busy, 0);
    trig_valid = 1'b1; trig_insn = {20'h3, 5'd5, 7'b0001011};
    @(negedge clk); trig_valid = 1'b0;
    check(!busy && !wb_req, "R1 nonzero rd ignored", busy, 0);
    @(negedge clk);
    check(!busy && !wb_req && !drain_hold, "R1 still idle", busy, 0);

    // directed corners
    run_fence(20'h0, 64'h8000_0000, 0, 0);       // R10
    run_fence(20'hFFFFF, 64'h8000_1000, 0, 0);   // all arrays
    run_fence(20'h2, 64'h0000_2004, 5, 7);       // skip array 0
    run_fence(20'h1, 64'hFFFF_FFFF_FFFF_FFFC, 3, 15); // pc wrap

    for (int t = 0; t < 20; t++) begin
      logic [19:0] bm;
      logic [PCW-1:0] pc;
      bm = 20'($urandom);
      pc = {32'($urandom), 32'($urandom)} & ~64'h3;
      run_fence(bm, pc, int'($urandom % 6), int'($urandom % 8));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule